// File: doc/BRIEF.md
# USB Device Suspend Clock-Gating Controller

This block follows the link state of a USB device controller and drives two clock-gate control levels: one that stops the PHY clock and one that gates the bus clock. Its inputs are single-cycle event pulses from the rest of the controller and from software-driven strobes. These are soft connect, soft disconnect, session end, bus reset, SETUP received, bus suspend, wakeup detected and remote-wakeup request.

The block runs from an always-on reference clock, so it keeps working while the clocks it controls are stopped. Gating and ungating each take two steps in a fixed order, with a settle interval after every step. A suspend only gates the clocks once a SETUP has been seen. Before that point, bus idle caused by plug noise could look like a suspend. At the end of each sequence the block compares the readback of both gate cells with the expected levels and reports any mismatch. Events that arrive while a sequence is running are held and then served in a fixed priority order.

Top module: `usb_suspend_gate`

## Requirements
- R1: After reset, `link_state` is OFF and every output is 0. The state encoding is OFF=0, IDLE=1, DEFAULT=2, ACTIVE=3, SUSPENDED=4.
- R2: A connect event sets the state to IDLE. A disconnect or a session-end event sets it to OFF, and the gate levels do not change.
- R3: A SETUP event sets the state to ACTIVE.
- R4: A bus reset first runs the ungating sequence. It then sets the state to DEFAULT, and at that point both gate outputs are 0.
- R5: A suspend event in state ACTIVE raises `phy_clk_stop`. It raises `bus_clk_gate` exactly SETTLE_CYC cycles later. After one further settle interval the state becomes SUSPENDED. `suspend_pulse` is issued once.
- R6: A suspend event in any state other than ACTIVE issues `suspend_pulse`. Both gate outputs stay 0 and the state is unchanged.
- R7: Ungating releases `bus_clk_gate` first and releases `phy_clk_stop` exactly SETTLE_CYC cycles later.
- R8: A wakeup event always runs the ungating sequence and issues `resume_pulse` once when that sequence ends. The state becomes ACTIVE only if it was SUSPENDED; otherwise it is unchanged.
- R9: A remote-wakeup request first ungates both clocks. Then `resume_sig` is high for exactly RES_CYC cycles, and both gate outputs are 0 throughout. The state does not change.
- R10: At the end of a gating sequence, `gate_err` is set if either readback input is 0. At the end of an ungating sequence, it is set if either readback input is 1. Otherwise `gate_err` is cleared at the end of each sequence.
- R11: Events that arrive during a sequence are kept pending and served one at a time, highest priority first: disconnect/session end, bus reset, wakeup, remote wakeup, suspend, SETUP, connect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_connect | input | 1 | Soft connect pulse |
| ev_disconnect | input | 1 | Soft disconnect pulse |
| ev_sess_end | input | 1 | Session-end pulse |
| ev_bus_reset | input | 1 | USB bus reset pulse |
| ev_setup | input | 1 | SETUP packet received pulse |
| ev_suspend | input | 1 | Bus suspend detected pulse |
| ev_wakeup | input | 1 | Host wakeup detected pulse |
| ev_rwake_req | input | 1 | Remote-wakeup request pulse |
| phy_stop_rb | input | 1 | Readback of the PHY-clock stop cell |
| bus_gate_rb | input | 1 | Readback of the bus-clock gate cell |
| link_state | output | 3 | Current link state (encoding in R1) |
| phy_clk_stop | output | 1 | PHY-clock stop control level |
| bus_clk_gate | output | 1 | Bus-clock gate control level |
| resume_sig | output | 1 | Resume-signaling enable |
| gate_err | output | 1 | Readback mismatch at the end of the last sequence |
| suspend_pulse | output | 1 | One-cycle pulse per suspend event served |
| resume_pulse | output | 1 | One-cycle pulse when a wakeup's ungating ends |

## Verification
The bench builds the block with SETTLE_CYC=4 and RES_CYC=20 in place of the defaults of 1000 and 2,000,000. The defaults correspond to 5 µs and 10 ms at 200 MHz. With these small values a full suspend, wakeup or remote-wakeup round trip takes a few dozen cycles, so one run can hold a long random event series with exact measurement of both step gaps and of the resume width. Short sequences also make it easy to land event pairs inside a running sequence, which exercises the pending priority order. Faulty readbacks can be injected to drive the error flag both ways.

// File: rtl/usg_pkg.sv
`timescale 1ns/1ps
package usg_pkg;
  typedef enum logic [2:0] {
    LNK_OFF     = 3'd0,
    LNK_IDLE    = 3'd1,
    LNK_DEFAULT = 3'd2,
    LNK_ACTIVE  = 3'd3,
    LNK_SUSP    = 3'd4
  } lnk_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_G1, SQ_G2, SQ_U1, SQ_U2, SQ_RES
  } seq_t;

  typedef enum logic [1:0] {
    PA_RESET, PA_WAKE, PA_RWAKE
  } post_t;

  // event slots, index 0 is served first
  localparam int NEV      = 7;
  localparam int EV_DISC  = 0;
  localparam int EV_BRST  = 1;
  localparam int EV_WAKE  = 2;
  localparam int EV_RWAKE = 3;
  localparam int EV_SUSP  = 4;
  localparam int EV_SETUP = 5;
  localparam int EV_CONN  = 6;
endpackage

// File: rtl/usg_evt_pend.sv
`timescale 1ns/1ps
module usg_evt_pend #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         take,
  output logic [N-1:0] grant
);
  logic [N-1:0] pend;
  logic         found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~(take ? grant : '0)) | ev;
  end
endmodule

// File: rtl/usg_settle_tmr.sv
`timescale 1ns/1ps
module usg_settle_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/usb_suspend_gate.sv
`timescale 1ns/1ps
module usb_suspend_gate
  import usg_pkg::*;
#(
  parameter int SETTLE_CYC = 1000,
  parameter int RES_CYC    = 2000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_connect,
  input  logic       ev_disconnect,
  input  logic       ev_sess_end,
  input  logic       ev_bus_reset,
  input  logic       ev_setup,
  input  logic       ev_suspend,
  input  logic       ev_wakeup,
  input  logic       ev_rwake_req,
  input  logic       phy_stop_rb,
  input  logic       bus_gate_rb,
  output logic [2:0] link_state,
  output logic       phy_clk_stop,
  output logic       bus_clk_gate,
  output logic       resume_sig,
  output logic       gate_err,
  output logic       suspend_pulse,
  output logic       resume_pulse
);
  localparam int MAXC = (SETTLE_CYC > RES_CYC) ? SETTLE_CYC : RES_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] SET_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] RES_LD = TW'(RES_CYC - 1);

  lnk_t  st;
  seq_t  seq;
  post_t post;

  logic [NEV-1:0] ev, grant;
  logic           take, t_load, t_zero;
  logic [TW-1:0]  t_val;

  assign ev[EV_DISC]  = ev_disconnect | ev_sess_end;
  assign ev[EV_BRST]  = ev_bus_reset;
  assign ev[EV_WAKE]  = ev_wakeup;
  assign ev[EV_RWAKE] = ev_rwake_req;
  assign ev[EV_SUSP]  = ev_suspend;
  assign ev[EV_SETUP] = ev_setup;
  assign ev[EV_CONN]  = ev_connect;

  assign take = (seq == SQ_IDLE);

  usg_evt_pend #(.N(NEV)) u_pend (
    .clk(clk), .rst(rst), .ev(ev), .take(take), .grant(grant)
  );

  // timer reload decode
  always_comb begin
    t_load = 1'b0;
    t_val  = SET_LD;
    case (seq)
      SQ_IDLE: t_load = grant[EV_BRST] | grant[EV_WAKE] | grant[EV_RWAKE]
                      | (grant[EV_SUSP] && st == LNK_ACTIVE);
      SQ_G1:   t_load = t_zero;
      SQ_U1:   t_load = t_zero;
      SQ_U2:   if (t_zero && post == PA_RWAKE) begin
                 t_load = 1'b1;
                 t_val  = RES_LD;
               end
      default: t_load = 1'b0;
    endcase
  end

  usg_settle_tmr #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .zero(t_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= LNK_OFF;
      seq           <= SQ_IDLE;
      post          <= PA_RESET;
      phy_clk_stop  <= 1'b0;
      bus_clk_gate  <= 1'b0;
      resume_sig    <= 1'b0;
      gate_err      <= 1'b0;
      suspend_pulse <= 1'b0;
      resume_pulse  <= 1'b0;
    end else begin
      suspend_pulse <= 1'b0;
      resume_pulse  <= 1'b0;
      case (seq)
        SQ_IDLE: begin
          if (grant[EV_DISC]) st <= LNK_OFF;
          else if (grant[EV_BRST] | grant[EV_WAKE] | grant[EV_RWAKE]) begin
            bus_clk_gate <= 1'b0;          // bus clock released first
            seq          <= SQ_U1;
            post         <= grant[EV_BRST] ? PA_RESET :
                            grant[EV_WAKE] ? PA_WAKE : PA_RWAKE;
          end else if (grant[EV_SUSP]) begin
            suspend_pulse <= 1'b1;
            if (st == LNK_ACTIVE) begin
              phy_clk_stop <= 1'b1;        // PHY clock stopped first
              seq          <= SQ_G1;
            end
          end else if (grant[EV_SETUP]) st <= LNK_ACTIVE;
          else if (grant[EV_CONN])      st <= LNK_IDLE;
        end
        SQ_G1: if (t_zero) begin
          bus_clk_gate <= 1'b1;
          seq          <= SQ_G2;
        end
        SQ_G2: if (t_zero) begin
          gate_err <= !(phy_stop_rb && bus_gate_rb);
          st       <= LNK_SUSP;
          seq      <= SQ_IDLE;
        end
        SQ_U1: if (t_zero) begin
          phy_clk_stop <= 1'b0;
          seq          <= SQ_U2;
        end
        SQ_U2: if (t_zero) begin
          gate_err <= phy_stop_rb || bus_gate_rb;
          seq      <= SQ_IDLE;
          case (post)
            PA_RESET: st <= LNK_DEFAULT;
            PA_WAKE: begin
              resume_pulse <= 1'b1;
              if (st == LNK_SUSP) st <= LNK_ACTIVE;
            end
            default: begin
              resume_sig <= 1'b1;
              seq        <= SQ_RES;
            end
          endcase
        end
        SQ_RES: if (t_zero) begin
          resume_sig <= 1'b0;
          seq        <= SQ_IDLE;
        end
        default: seq <= SQ_IDLE;
      endcase
    end
  end

  assign link_state = st;
endmodule

// File: rtl/usb_suspend_gate_chk.sv
`timescale 1ns/1ps
module usb_suspend_gate_chk #(
  parameter int RES_CYC = 2000000
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] link_state,
  input logic       phy_clk_stop,
  input logic       bus_clk_gate,
  input logic       resume_sig
);
  localparam int CW = $clog2(RES_CYC + 1) + 1;
  logic [CW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst)             rcnt <= '0;
    else if (resume_sig) rcnt <= rcnt + 1'b1;
    else                 rcnt <= '0;
  end

  // R5
  gate_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_clk_gate) |-> phy_clk_stop);

  // R6
  gate_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_clk_stop) |-> link_state == 3'd3);

  // R7
  ungate_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_clk_stop) |-> !bus_clk_gate);

  // R4
  default_ungated_chk: assert property (@(posedge clk) disable iff (rst)
    (link_state == 3'd2 && $past(link_state) != 3'd2) |-> (!phy_clk_stop && !bus_clk_gate));

  // R9
  resume_ungated_chk: assert property (@(posedge clk) disable iff (rst)
    resume_sig |-> (!phy_clk_stop && !bus_clk_gate));

  // R9
  resume_max_chk: assert property (@(posedge clk) disable iff (rst)
    resume_sig |-> rcnt < CW'(RES_CYC));

  // R9
  resume_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(resume_sig) |-> rcnt == CW'(RES_CYC));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    link_state <= 3'd4);
endmodule

bind usb_suspend_gate usb_suspend_gate_chk #(.RES_CYC(RES_CYC)) u_chk (
  .clk(clk), .rst(rst), .link_state(link_state), .phy_clk_stop(phy_clk_stop),
  .bus_clk_gate(bus_clk_gate), .resume_sig(resume_sig)
);

// File: tb/test_usb_suspend_gate.sv
`timescale 1ns/1ps
module test_usb_suspend_gate;
  localparam int S = 4;
  localparam int R = 20;
  localparam int GAP = 60;
  localparam int OFF = 0, IDLE = 1, DEF = 2, ACT = 3, SUS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ev_connect = 0, ev_disconnect = 0, ev_sess_end = 0, ev_bus_reset = 0;
  logic ev_setup = 0, ev_suspend = 0, ev_wakeup = 0, ev_rwake_req = 0;
  logic flt_phy = 0, flt_bus = 0;
  logic phy_stop_rb, bus_gate_rb;
  logic [2:0] link_state;
  logic phy_clk_stop, bus_clk_gate, resume_sig, gate_err, suspend_pulse, resume_pulse;

  int n_chk = 0, n_bad = 0, n_sus = 0, n_res = 0, cyc = 0;
  int es = 0, eg = 0;

  always #2.5 clk = ~clk;

  assign phy_stop_rb = phy_clk_stop & ~flt_phy;
  assign bus_gate_rb = bus_clk_gate & ~flt_bus;

  usb_suspend_gate #(.SETTLE_CYC(S), .RES_CYC(R)) i_usb_suspend_gate (
    .clk(clk), .rst(rst), .ev_connect(ev_connect), .ev_disconnect(ev_disconnect),
    .ev_sess_end(ev_sess_end), .ev_bus_reset(ev_bus_reset), .ev_setup(ev_setup),
    .ev_suspend(ev_suspend), .ev_wakeup(ev_wakeup), .ev_rwake_req(ev_rwake_req),
    .phy_stop_rb(phy_stop_rb), .bus_gate_rb(bus_gate_rb), .link_state(link_state),
    .phy_clk_stop(phy_clk_stop), .bus_clk_gate(bus_clk_gate), .resume_sig(resume_sig),
    .gate_err(gate_err), .suspend_pulse(suspend_pulse), .resume_pulse(resume_pulse)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst && suspend_pulse) n_sus++;
    if (!rst && resume_pulse)  n_res++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
    summary();
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // event codes: 0 disc,1 sess_end,2 connect,3 bus_reset,4 setup,5 suspend,6 wakeup,7 rwake
  task automatic drive(int code, logic v);
    case (code)
      0: ev_disconnect = v;  1: ev_sess_end = v;  2: ev_connect = v;
      3: ev_bus_reset = v;   4: ev_setup = v;     5: ev_suspend = v;
      6: ev_wakeup = v;      default: ev_rwake_req = v;
    endcase
  endtask

  task automatic pulse(int code);
    @(negedge clk); drive(code, 1'b1);
    @(negedge clk); drive(code, 1'b0);
  endtask

  task automatic settle();
    repeat (GAP) @(negedge clk);
  endtask

  // bench model of the requirements
  function automatic void model(int code);
    case (code)
      0, 1: es = OFF;
      2: es = IDLE;
      3: begin eg = 0; es = DEF; end
      4: es = ACT;
      5: if (es == ACT) begin eg = 1; es = SUS; end
      6: begin eg = 0; if (es == SUS) es = ACT; end
      default: eg = 0;
    endcase
  endfunction

  task automatic apply(int code);
    pulse(code); model(code); settle();
  endtask

  task automatic chk_all(string req);
    chk({req, " state"}, int'(link_state), es);
    chk({req, " phy"}, int'(phy_clk_stop), eg);
    chk({req, " bus"}, int'(bus_clk_gate), eg);
  endtask

  initial begin
    int cnt, s0, r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(link_state), OFF);
    chk("R1 outs", int'({phy_clk_stop, bus_clk_gate, resume_sig, gate_err, suspend_pulse, resume_pulse}), 0);

    apply(2); chk_all("R2 connect");
    s0 = n_sus; apply(5);
    chk_all("R6 suspend idle"); chk("R6 pulse", n_sus - s0, 1);
    apply(3); chk_all("R4 reset");
    apply(4); chk_all("R3 setup");

    // R5 gating gap
    s0 = n_sus; pulse(5); model(5); cnt = 0;
    while (!phy_clk_stop) @(negedge clk);
    chk("R5 bus low at phy rise", int'(bus_clk_gate), 0);
    while (!bus_clk_gate) begin @(negedge clk); cnt++; end
    chk("R5 gate gap", cnt, S);
    settle(); chk_all("R5 suspended"); chk("R5 pulse", n_sus - s0, 1);
    chk("R10 no err", int'(gate_err), 0);

    // R7 ungating gap, R8 wakeup from suspended
    r0 = n_res; pulse(6); model(6); cnt = 0;
    while (bus_clk_gate) @(negedge clk);
    chk("R7 phy still set", int'(phy_clk_stop), 1);
    while (phy_clk_stop) begin @(negedge clk); cnt++; end
    chk("R7 ungate gap", cnt, S);
    settle(); chk_all("R8 wake"); chk("R8 pulse", n_res - r0, 1);
    r0 = n_res; apply(6); chk_all("R8 wake active"); chk("R8 pulse2", n_res - r0, 1);

    // R9 remote wakeup
    apply(5); chk_all("R9 pre");
    pulse(7); model(7); cnt = 0;
    while (!resume_sig) @(negedge clk);
    chk("R9 ungated at resume", int'({phy_clk_stop, bus_clk_gate}), 0);
    while (resume_sig) begin @(negedge clk); cnt++; end
    chk("R9 resume width", cnt, R);
    settle(); chk_all("R9 post");
    apply(6); chk_all("R9 wake");

    // R10 readback fault on gating, then clean ungate clears it
    flt_bus = 1'b1; apply(5); chk("R10 err set", int'(gate_err), 1);
    flt_bus = 1'b0; apply(6); chk("R10 err clear", int'(gate_err), 0);
    flt_phy = 1'b1; apply(5); flt_phy = 1'b0;
    chk("R10 phy fault", int'(gate_err), 1);
    apply(6); chk("R10 clear2", int'(gate_err), 0);

    // R11 priority: setup and bus reset during gating
    pulse(5); repeat (2) @(negedge clk);
    @(negedge clk); ev_setup = 1; ev_bus_reset = 1;
    @(negedge clk); ev_setup = 0; ev_bus_reset = 0;
    settle(); settle(); es = ACT; eg = 0; chk_all("R11 reset before setup");
    // R11 priority: connect and disconnect during ungating
    pulse(6); repeat (2) @(negedge clk);
    @(negedge clk); ev_connect = 1; ev_disconnect = 1;
    @(negedge clk); ev_connect = 0; ev_disconnect = 0;
    settle(); es = IDLE; eg = 0; chk_all("R11 disc before conn");
    apply(1); chk_all("R2 sess end");

    // constrained random series
    void'($urandom(32'd1234));
    for (int i = 0; i < 80; i++) begin
      int code;
      code = (es == ACT && $urandom_range(0, 2) == 0) ? 5 : int'($urandom_range(0, 7));
      apply(code);
      chk_all($sformatf("R2-rand%0d code%0d", i, code));
      chk("R10 rand err", int'(gate_err), 0);
    end
    summary();
  end
endmodule